// File: doc/BRIEF.md
# Bus Turnaround Idle-Cycle Inserter

This block gates the access request stream between a CPU-side requester and an external memory bus sequencer that serves several chip-select areas. Each area owns a 32-bit control register. A 3-bit recovery field in that register sets how many idle bus cycles must follow a write to the area before the next access of any kind is let through. The block remembers whether the last accepted access was a write. After a write it counts the decoded number of idle cycles down, and only then accepts the next request and asserts its chip select.

A separate strobe-control register holds one bit. It decides whether the memory strobes and secondary clock float or stay driven while the chip is in standby or has released the bus. The area registers and the strobe bit take their initial values only from power-on reset. A manual reset clears the idle sequencer and leaves the configuration as it was.

The request side is a valid/ready stream. The requester raises `req_valid` with `req_write` and `req_area`, and holds them steady until `req_ready` is high at a clock edge. `req_ready` may be low for any number of cycles, and it does not depend on any later change of `req_valid`.

Top module: `turnaround_gate`

## Requirements
- R1: The idle count comes from bits 30:28 of the area register. The codes 0 to 7 map to 0, 1, 2, 4, 6, 8, 10 and 12 idle cycles.
- R2: An accepted read starts no idle window. The next request may be accepted in the very next cycle.
- R3: If a write to area A is accepted in cycle t, the idle count N is taken from A's register at that moment. The next acceptance cannot happen before cycle t+N+1, whether it is a read or a write and whatever its area.
- R4: While idle cycles remain, `req_ready` is low and `cs_sel` is all zero. A request that is held through the window is accepted in the first cycle after the count reaches zero.
- R5: The config address map places area k at address k (k < NUM_AREAS), and the strobe-control register at address NUM_AREAS, bit 0. Bit 31 of an area register always reads 0 and ignores writes. All other area bits read back as written. Unmapped addresses read 0.
- R6: A config write made while a window is counting changes only later windows, never the current one.
- R7: Power-on reset loads every area register with 0x36DB0600 (code 3, 4 idle cycles) and clears the strobe bit. After reset, the first request is accepted without delay.
- R8: Manual reset ends any idle window and keeps `req_ready` low while it is asserted. It leaves all config registers unchanged.
- R9: When `standby` or `bus_release` is high, `strobe_oe` equals the strobe bit and `req_ready` is low. Otherwise `strobe_oe` is 1.
- R10: In a cycle where a request is accepted, `cs_sel` is the one-hot code of `req_area`. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, async |
| mrst_n | input | 1 | Manual reset, active low, async |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | ADDR_W | Config register address |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data for `cfg_addr` |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access accepted (grant) |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_area | input | AREA_W | Target chip-select area |
| cs_sel | output | NUM_AREAS | One-hot chip select for the accepted access |
| standby | input | 1 | Chip is in standby |
| bus_release | input | 1 | External bus has been released |
| strobe_oe | output | 1 | Output enable for strobes and secondary clock |

## Verification
The embedded properties check on every cycle that grant and chip select stay quiet while a window is counting, and that chip selects stay one-hot. They also check that a read never opens a window and that a write with a nonzero code blocks the following cycle. Strobe enable is checked against the hold inputs, and reserved bit 31 against zero. The exact length of each window can only be shown by the bench's scenarios: they measure the gap for all eight codes, rewrite a register during a window, and assert manual reset partway through a window. The same applies to the power-on values of the registers.

// File: rtl/turnaround_pkg.sv
package turnaround_pkg;

  localparam int REG_W     = 32;
  localparam int CODE_LSB  = 28;
  localparam int CODE_W    = 3;
  localparam int RSVD_BIT  = 31;
  localparam int IDLE_W    = 4;

  // Non-linear recovery code: 0,1,2 pass straight; above that two per step.
  function automatic logic [IDLE_W-1:0] idle_decode(input logic [CODE_W-1:0] code);
    logic [IDLE_W-1:0] n;
    case (code)
      3'd0: n = 4'd0;
      3'd1: n = 4'd1;
      3'd2: n = 4'd2;
      3'd3: n = 4'd4;
      3'd4: n = 4'd6;
      3'd5: n = 4'd8;
      3'd6: n = 4'd10;
      default: n = 4'd12;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/turnaround_cfg_regs.sv
module turnaround_cfg_regs
  import turnaround_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int AREA_W    = 3,
  parameter int ADDR_W    = 4,
  parameter logic [REG_W-1:0] AREA_INIT = 32'h36DB_0600
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [AREA_W-1:0] look_area,
  output logic [CODE_W-1:0] look_code,
  output logic              hiz_keep
);

  localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << RSVD_BIT);
  localparam logic [ADDR_W-1:0] STROBE_ADDR = ADDR_W'(NUM_AREAS);

  logic [REG_W-1:0] area_q [NUM_AREAS];
  logic             hiz_q;

  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_area
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                   area_q[k] <= AREA_INIT & KEEP_MASK;
      else if (we && addr == MY_ADDR) area_q[k] <= wdata & KEEP_MASK;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          hiz_q <= 1'b0;
    else if (we && addr == STROBE_ADDR)  hiz_q <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (addr < STROBE_ADDR)        rdata = area_q[addr[AREA_W-1:0]];
    else if (addr == STROBE_ADDR)  rdata = {{(REG_W-1){1'b0}}, hiz_q};
  end

  assign look_code = area_q[look_area][CODE_LSB +: CODE_W];
  assign hiz_keep  = hiz_q;

  // R5: reserved bit never visible on the read port
  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!por_n)
    rdata[RSVD_BIT] == 1'b0);

endmodule

// File: rtl/turnaround_idle_timer.sv
module turnaround_idle_timer
  import turnaround_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDLE_W-1:0] load_val,
  output logic [IDLE_W-1:0] remain
);

  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign remain = cnt_q;

  // R4: a running window only ever moves down by one
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R2: with no load, an empty window stays empty
  a_r2_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/turnaround_gate.sv
module turnaround_gate
  import turnaround_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  parameter int ADDR_W    = $clog2(NUM_AREAS + 1),
  parameter logic [31:0] AREA_INIT = 32'h36DB_0600
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 mrst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AREA_W-1:0]    req_area,
  output logic [NUM_AREAS-1:0] cs_sel,
  input  logic                 standby,
  input  logic                 bus_release,
  output logic                 strobe_oe
);

  logic              seq_rst_n;
  logic              hold;
  logic              accept;
  logic [CODE_W-1:0] area_code;
  logic [IDLE_W-1:0] idle_left;
  logic              hiz_keep;

  assign seq_rst_n = por_n & mrst_n;
  assign hold      = standby | bus_release;

  turnaround_cfg_regs #(
    .NUM_AREAS (NUM_AREAS),
    .AREA_W    (AREA_W),
    .ADDR_W    (ADDR_W),
    .AREA_INIT (AREA_INIT)
  ) u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .look_area (req_area),
    .look_code (area_code),
    .hiz_keep  (hiz_keep)
  );

  turnaround_idle_timer u_timer (
    .clk      (clk),
    .rst_n    (seq_rst_n),
    .load     (accept && req_write),
    .load_val (idle_decode(area_code)),
    .remain   (idle_left)
  );

  assign req_ready = seq_rst_n && !hold && (idle_left == '0);
  assign accept    = req_valid && req_ready;

  for (genvar k = 0; k < NUM_AREAS; k++) begin : g_cs
    assign cs_sel[k] = accept && (req_area == AREA_W'(k));
  end

  assign strobe_oe = hold ? hiz_keep : 1'b1;

  // R4: nothing leaves while a window is counting
  a_r4_quiet: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (idle_left != '0) |-> (!req_ready && cs_sel == '0));

  // R10: chip select one-hot and matched to the accepted area
  a_r10_onehot: assert property (@(posedge clk) disable iff (!seq_rst_n)
    $onehot0(cs_sel));
  a_r10_match: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (req_valid && req_ready) |-> cs_sel[req_area]);

  // R2: an accepted read opens no window
  a_r2_read_free: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (req_valid && req_ready && !req_write) |=> (idle_left == '0));

  // R3: a write with a nonzero code blocks the next cycle
  a_r3_write_gap: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (req_valid && req_ready && req_write && area_code != '0) |=> !req_ready);

  // R9: strobe enable follows the hold inputs and the strobe bit
  a_r9_oe_run: assert property (@(posedge clk) disable iff (!por_n)
    !hold |-> strobe_oe);
  a_r9_oe_float: assert property (@(posedge clk) disable iff (!por_n)
    (hold && !hiz_keep) |-> !strobe_oe);
  a_r9_no_grant: assert property (@(posedge clk) disable iff (!por_n)
    hold |-> !req_ready);

endmodule

// File: tb/turnaround_gate_bench.sv
`timescale 1ns/1ps
module turnaround_gate_bench;

  localparam int NA = 8;
  localparam int AW = 3;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          por_n, mrst_n, cfg_we;
  logic [DW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_area;
  logic [NA-1:0] cs_sel;
  logic          standby, bus_release, strobe_oe;

  turnaround_gate u_turnaround_gate (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_reg [NA];
  logic        m_hiz;
  int          m_cnt;
  logic        obs_ready;

  function automatic int exp_idle(input int code);
    return (code < 3) ? code : 2 * (code - 1);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_por();
    for (int k = 0; k < NA; k++) m_reg[k] = 32'h36DB_0600;
    m_hiz = 1'b0;
    m_cnt = 0;
  endtask

  // One cycle: inputs already set after a negedge; check, then step the model.
  task automatic cyc();
    logic hold, exp_rdy, acc;
    logic [31:0] exp_rd;
    #1;
    if (!por_n) model_por();
    if (!por_n || !mrst_n) m_cnt = 0;
    hold    = standby | bus_release;
    exp_rdy = por_n && mrst_n && !hold && (m_cnt == 0);
    acc     = req_valid && exp_rdy;
    obs_ready = req_ready;
    chk("R4 ready", req_ready, exp_rdy);
    chk("R10 cs_sel", cs_sel, acc ? (NA'(1) << req_area) : '0);
    chk("R9 strobe_oe", strobe_oe, hold ? m_hiz : 1'b1);
    exp_rd = (cfg_addr < NA) ? m_reg[cfg_addr[AW-1:0]] :
             (cfg_addr == NA) ? {31'b0, m_hiz} : 32'h0;
    chk("R5 rdata", cfg_rdata, exp_rd);
    @(posedge clk);
    if (por_n && mrst_n) begin
      if (acc && req_write) m_cnt = exp_idle(int'(m_reg[req_area][30:28]));
      else if (m_cnt > 0)   m_cnt--;
    end
    if (por_n && cfg_we) begin
      if (cfg_addr < NA)       m_reg[cfg_addr[AW-1:0]] = cfg_wdata & 32'h7FFF_FFFF;
      else if (cfg_addr == NA) m_hiz = cfg_wdata[0];
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    cfg_we = 0; req_valid = 0; standby = 0; bus_release = 0;
  endtask

  task automatic drain();
    quiet();
    for (int i = 0; i < 14; i++) cyc();
  endtask

  task automatic wr_cfg(input int a, input logic [31:0] d);
    quiet(); cfg_we = 1; cfg_addr = DW'(a); cfg_wdata = d; cyc(); cfg_we = 0;
  endtask

  // Accept a write to area a, then hold a request and measure the gap.
  task automatic gap_after_write(input int a, input logic nxt_wr, input int nxt_area,
                                 input bit rewrite, output int gap);
    quiet(); req_valid = 1; req_write = 1; req_area = AW'(a); cyc();
    req_write = nxt_wr; req_area = AW'(nxt_area);
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      if (rewrite && i == 0) begin
        cfg_we = 1; cfg_addr = DW'(a); cfg_wdata = 32'h0000_0000;
      end else cfg_we = 0;
      cyc();
      if (obs_ready) break;
      gap++;
    end
    cfg_we = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'd1234));
    por_n = 0; mrst_n = 1; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 0; req_write = 0; req_area = '0; standby = 0; bus_release = 0;
    model_por();
    @(negedge clk); cyc(); cyc();
    por_n = 1;
    // R7: reset values of every register
    for (int k = 0; k <= NA; k++) begin
      cfg_addr = DW'(k); cyc();
      chk("R7 reset value", cfg_rdata, (k < NA) ? 32'h36DB_0600 : 32'h0);
    end
    // R7: first request accepted at once
    req_valid = 1; req_write = 0; req_area = 2; cyc();
    chk("R7 first grant", obs_ready, 1);
    // R5: reserved bit and unmapped address
    wr_cfg(1, 32'hFFFF_FFFF); cfg_addr = 1; cyc();
    chk("R5 bit31 ignored", cfg_rdata, 32'h7FFF_FFFF);
    cfg_addr = DW'(NA + 3); cyc();
    chk("R5 unmapped", cfg_rdata, 0);
    // R1 and R3: each code, next access read or write to another area
    for (int c = 0; c < 8; c++) begin
      drain();
      wr_cfg(c % NA, {1'b0, 3'(c), 28'h0});
      gap_after_write(c % NA, c[0], (c + 3) % NA, 0, gap);
      chk($sformatf("R1 R3 gap code %0d", c), gap, exp_idle(c));
    end
    // R2: read then read, read then write
    drain();
    quiet(); req_valid = 1; req_write = 0; req_area = 4; cyc();
    cyc(); chk("R2 read-read", obs_ready, 1);
    req_write = 1; cyc(); chk("R2 read-write", obs_ready, 1);
    // R6: rewrite during window does not shorten it
    drain();
    wr_cfg(5, {1'b0, 3'd7, 28'h0});
    gap_after_write(5, 0, 5, 1, gap);
    chk("R6 window kept", gap, 12);
    drain();
    gap_after_write(5, 0, 5, 0, gap);
    chk("R6 later window uses new code", gap, 0);
    // R8: manual reset mid-window, registers kept
    drain();
    wr_cfg(6, {1'b0, 3'd6, 28'h123});
    quiet(); req_valid = 1; req_write = 1; req_area = 6; cyc();
    cyc(); cyc();
    mrst_n = 0; cyc();
    chk("R8 ready low in manual reset", obs_ready, 0);
    mrst_n = 1; cyc();
    chk("R8 window cleared", obs_ready, 1);
    quiet(); cfg_addr = 6; cyc();
    chk("R8 register kept", cfg_rdata, 32'h6000_0123);
    // R9: strobe bit both ways
    wr_cfg(NA, 32'h1); standby = 1; cyc();
    chk("R9 keep driven", strobe_oe, 1);
    wr_cfg(NA, 32'h0); bus_release = 1; req_valid = 1; cyc();
    chk("R9 float", strobe_oe, 0);
    chk("R9 no grant in hold", obs_ready, 0);
    // Random mix checked against the model each cycle
    quiet();
    for (int i = 0; i < 4000; i++) begin
      cfg_we      = ($urandom % 8) == 0;
      cfg_addr    = DW'($urandom % (NA + 2));
      cfg_wdata   = $urandom;
      req_valid   = ($urandom % 4) != 0;
      req_write   = $urandom % 2;
      req_area    = AW'($urandom);
      standby     = ($urandom % 32) == 0;
      bus_release = ($urandom % 32) == 0;
      mrst_n      = ($urandom % 200) != 0;
      cyc();
    end
    mrst_n = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule